// File: doc/BRIEF.md
# Five-Level Third-Order Noise-Shaping Modulator

This block turns a stream of oversampled 18-bit two's-complement audio words into a 3-bit level code from 0 to 4. One instance serves one channel. A sample word arrives with a strobe at eight times the audio rate. A hold register keeps that word for every modulator step until the next strobe. An internal tick generator sets the modulator step rate from the system clock. One step every 8 clocks gives 48 steps per audio sample period at a 384x system clock. One step every 4 clocks gives 64 steps at a 256x system clock.

Each step passes the held word through three cascaded accumulators. Each accumulator has a unit delay, and each one subtracts the analog weight of the previously issued code. The last accumulator drives a five-level quantizer. Code 2 is the mid level (bipolar zero, half supply). Code 4 weighs positive full scale and code 0 weighs negative full scale. Every accumulator is wider than the input and clamps at its rails instead of wrapping, so the loop recovers after a hard overload.

Top module: `sdm5_modulator`

## Requirements
- R1: A synchronous active-high `rst` clears the hold register, all three accumulators and the tick counter, and forces `mod_code` to 2. While reset is held, `mod_tick` stays low.
- R2: When `smp_valid` is high at a clock edge, the hold register takes `smp_data` at that edge. The held word is used by every later step until the next strobe. A step that falls on the same edge as a strobe still uses the previous word.
- R3: `mod_code` never exceeds 4.
- R4: With `clk_ratio_384` high, `mod_tick` is high for one clock in every 8 (50 ticks in 400 clocks). With it low, the tick is high for one clock in every 4 (100 ticks in 400 clocks).
- R5: From reset, an all-zero input keeps `mod_code` at 2 on every step.
- R6: On each step the code value c held before the step has weight F = (c-2)·2^(IN_W-2). Stage 1 adds floor((h-F)/2^SHIFT1), where h is the held word. Stage 2 adds floor((a1-F)/2^SHIFT2) and stage 3 adds floor((a2-F)/2^SHIFT3), where a1 and a2 are the stage values before the step. The defaults are SHIFT1=2, SHIFT2=2 and SHIFT3=1.
- R7: The new code comes from the new stage-3 value v, with T = 2^(IN_W-3). The code is 4 if v ≥ 3T, 3 if T ≤ v < 3T, 2 if -T < v < T, 1 if -3T < v ≤ -T, and 0 if v ≤ -3T.
- R8: Each stage result is clamped to the signed range of ACC_W bits, [-2^(ACC_W-1), 2^(ACC_W-1)-1].
- R9: `mod_code` changes only at a clock edge where `mod_tick` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| clk_ratio_384 | input | 1 | 1: system clock is 384x audio rate (step every 8 clocks); 0: 256x (step every 4) |
| smp_valid | input | 1 | Strobe that loads a new oversampled word |
| smp_data | input | IN_W | Oversampled two's-complement sample |
| mod_tick | output | 1 | High on the clock whose edge performs a modulator step |
| mod_code | output | 3 | Quantizer level code, 0 to 4 |

## Verification
The clamping of the accumulators is the hardest behaviour to reach from the ports. With the default width, the loop's own feedback keeps every stage well inside its range. To reach it, the bench runs a second instance whose accumulators are only as wide as the input. It feeds both instances words that swing between the negative and positive extremes every couple of samples, and an independent model counts how often a clamp takes effect. Strobes that land on the same clock as a step are produced by a random strobe pattern, and the quantizer boundaries are approached by words placed one LSB either side of each threshold.

// File: rtl/sdm5_pkg.sv
package sdm5_pkg;

  typedef logic [2:0] code_t;

  localparam code_t CODE_MID = 3'd2;

  // Weight of a level code: (c-2) * fs/2, so code 4 = +fs, code 0 = -fs.
  function automatic longint fb_level(input code_t c, input longint fs);
    return (longint'(c) - 64'sd2) * (fs >>> 1);
  endfunction

  // Five-level slicer, thresholds at +-fs/4 and +-3fs/4.
  function automatic code_t quantize(input longint v, input longint fs);
    longint t;
    t = fs >>> 2;
    if (v >= 3 * t)       return 3'd4;
    else if (v >= t)      return 3'd3;
    else if (v > -t)      return 3'd2;
    else if (v > -3 * t)  return 3'd1;
    else                  return 3'd0;
  endfunction

  function automatic longint rail_hi(input int w);
    return (64'sd1 <<< (w - 1)) - 64'sd1;
  endfunction

  function automatic longint rail_lo(input int w);
    return -(64'sd1 <<< (w - 1));
  endfunction

  function automatic longint clamp(input longint v, input int w);
    if (v > rail_hi(w))      return rail_hi(w);
    else if (v < rail_lo(w)) return rail_lo(w);
    else                     return v;
  endfunction

  function automatic logic clipped(input longint v, input int w);
    return (v > rail_hi(w)) || (v < rail_lo(w));
  endfunction

endpackage

// File: rtl/sdm5_rate_gen.sv
module sdm5_rate_gen #(
  parameter int DIV_HI = 8,
  parameter int DIV_LO = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic sel_hi,
  output logic tick
);
  localparam int CW = $clog2(DIV_HI);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last;

  always_comb begin
    last = sel_hi ? CW'(DIV_HI - 1) : CW'(DIV_LO - 1);
    tick = (cnt_q == last);
  end

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (cnt_q >= last) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sdm5_sample_hold.sv
module sdm5_sample_hold #(
  parameter int IN_W = 18
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   load,
  input  logic [IN_W-1:0]        din,
  output logic signed [IN_W-1:0] hold_q
);
  always_ff @(posedge clk) begin
    if (rst)       hold_q <= '0;
    else if (load) hold_q <= $signed(din);
  end
endmodule

// File: rtl/sdm5_integ.sv
module sdm5_integ
  import sdm5_pkg::*;
#(
  parameter int ACC_W = 22,
  parameter int FB_W  = 19,
  parameter int SHIFT = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic signed [ACC_W-1:0] src,
  input  logic signed [FB_W-1:0]  fb,
  output logic signed [ACC_W-1:0] acc_q,
  output logic signed [ACC_W-1:0] acc_nxt,
  output logic                    clip
);
  longint sum;
  longint sat_v;

  always_comb begin
    sum     = longint'(acc_q) + ((longint'(src) - longint'(fb)) >>> SHIFT);
    clip    = clipped(sum, ACC_W);
    sat_v   = clamp(sum, ACC_W);
    acc_nxt = sat_v[ACC_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)     acc_q <= '0;
    else if (en) acc_q <= acc_nxt;
  end
endmodule

// File: rtl/sdm5_modulator.sv
module sdm5_modulator
  import sdm5_pkg::*;
#(
  parameter int IN_W   = 18,
  parameter int ACC_W  = IN_W + 4,
  parameter int SHIFT1 = 2,
  parameter int SHIFT2 = 2,
  parameter int SHIFT3 = 1,
  parameter int DIV_HI = 8,
  parameter int DIV_LO = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clk_ratio_384,
  input  logic            smp_valid,
  input  logic [IN_W-1:0] smp_data,
  output logic            mod_tick,
  output logic [2:0]      mod_code
);
  localparam int     FB_W       = IN_W + 1;
  localparam int     STAGES     = 3;
  localparam longint FULL_SCALE = 64'sd1 <<< (IN_W - 1);

  logic                    tick;
  logic signed [IN_W-1:0]  hold_q;
  code_t                   code_q;
  longint                  fbl;
  logic signed [FB_W-1:0]  fb;
  logic signed [ACC_W-1:0] src  [STAGES];
  logic signed [ACC_W-1:0] acc  [STAGES];
  logic signed [ACC_W-1:0] nxt  [STAGES];
  logic [STAGES-1:0]       clip_all;
  logic [STAGES*ACC_W-1:0] acc_all;
  logic [STAGES*ACC_W-1:0] nxt_all;
  logic                    loop_idle;

  sdm5_rate_gen #(.DIV_HI(DIV_HI), .DIV_LO(DIV_LO)) u_rate (
    .clk(clk), .rst(rst), .sel_hi(clk_ratio_384), .tick(tick)
  );

  sdm5_sample_hold #(.IN_W(IN_W)) u_hold (
    .clk(clk), .rst(rst), .load(smp_valid), .din(smp_data), .hold_q(hold_q)
  );

  always_comb begin
    fbl = fb_level(code_q, FULL_SCALE);
    fb  = fbl[FB_W-1:0];
  end

  assign src[0] = ACC_W'(hold_q);

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    localparam int SH = (k == 0) ? SHIFT1 : (k == 1) ? SHIFT2 : SHIFT3;
    if (k > 0) begin : g_chain
      assign src[k] = acc[k-1];
    end
    sdm5_integ #(.ACC_W(ACC_W), .FB_W(FB_W), .SHIFT(SH)) u_integ (
      .clk(clk), .rst(rst), .en(tick),
      .src(src[k]), .fb(fb),
      .acc_q(acc[k]), .acc_nxt(nxt[k]), .clip(clip_all[k])
    );
    assign acc_all[k*ACC_W +: ACC_W] = acc[k];
    assign nxt_all[k*ACC_W +: ACC_W] = nxt[k];
  end

  always_ff @(posedge clk) begin
    if (rst)       code_q <= CODE_MID;
    else if (tick) code_q <= quantize(longint'(nxt[STAGES-1]), FULL_SCALE);
  end

  assign loop_idle = (hold_q == '0) && (acc_all == '0) && (code_q == CODE_MID);
  assign mod_tick  = tick;
  assign mod_code  = code_q;
endmodule

// File: rtl/sdm5_modulator_chk.sv
module sdm5_modulator_chk #(
  parameter int IN_W  = 18,
  parameter int ACC_W = 22
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   smp_valid,
  input logic [IN_W-1:0]        smp_data,
  input logic                   mod_tick,
  input logic [2:0]             mod_code,
  input logic signed [IN_W-1:0] hold_q,
  input logic                   loop_idle,
  input logic [2:0]             clip_all,
  input logic [3*ACC_W-1:0]     acc_all,
  input logic [3*ACC_W-1:0]     nxt_all
);
  localparam logic [ACC_W-1:0] RAIL_HI = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] RAIL_LO = {1'b1, {(ACC_W-1){1'b0}}};

  AST_CODE_RANGE: assert property (@(posedge clk) disable iff (rst)
    mod_code <= 3'd4); // R3

  AST_RESET_MID: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (mod_code == 3'd2)); // R1

  AST_CODE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    !$past(mod_tick) |-> $stable(mod_code)); // R9

  AST_HOLD_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    smp_valid |=> ($unsigned(hold_q) == $past(smp_data))); // R2

  AST_ZERO_MID: assert property (@(posedge clk) disable iff (rst)
    (mod_tick && loop_idle) |=> (mod_code == 3'd2)); // R5

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (rst)
    mod_tick |=> !mod_tick); // R4

  AST_STEP_LOAD: assert property (@(posedge clk) disable iff (rst)
    mod_tick |=> (acc_all == $past(nxt_all))); // R6

  for (genvar k = 0; k < 3; k++) begin : g_rail
    AST_CLIP_RAIL: assert property (@(posedge clk) disable iff (rst)
      (mod_tick && clip_all[k]) |=>
        ((acc_all[k*ACC_W +: ACC_W] == RAIL_HI) || (acc_all[k*ACC_W +: ACC_W] == RAIL_LO))); // R8
  end
endmodule

bind sdm5_modulator sdm5_modulator_chk #(.IN_W(IN_W), .ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
  .mod_tick(mod_tick), .mod_code(mod_code), .hold_q(hold_q),
  .loop_idle(loop_idle), .clip_all(clip_all), .acc_all(acc_all), .nxt_all(nxt_all)
);

// File: tb/sdm5_modulator_tb.sv
`timescale 1ns/1ps
module sdm5_modulator_tb;
  localparam int     IN_W = 18;
  localparam longint FS   = 131072;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ratio = 1'b1;
  logic valid = 1'b0;
  logic [IN_W-1:0] data = '0;
  logic tick_a, tick_b;
  logic [2:0] code_a, code_b;
  logic [2:0] dcode [2];
  logic       dtick [2];

  always #2.5 clk = ~clk;

  sdm5_modulator #(.IN_W(IN_W)) u_dut (
    .clk(clk), .rst(rst), .clk_ratio_384(ratio), .smp_valid(valid),
    .smp_data(data), .mod_tick(tick_a), .mod_code(code_a)
  );
  sdm5_modulator #(.IN_W(IN_W), .ACC_W(IN_W)) u_dut_narrow (
    .clk(clk), .rst(rst), .clk_ratio_384(ratio), .smp_valid(valid),
    .smp_data(data), .mod_tick(tick_b), .mod_code(code_b)
  );

  assign dcode[0] = code_a;
  assign dcode[1] = code_b;
  assign dtick[0] = tick_a;
  assign dtick[1] = tick_b;

  int checks = 0, fails = 0, sat_hits = 0;
  int seen4 = 0, seen0 = 0, tick_count = 0, non_mid = 0;
  int cyc = 0;
  int m_cnt = 0;
  longint m_acc [2][3];
  int m_code [2];
  longint m_hold [2];
  int prev_code [2];
  bit prev_tick = 1'b0;
  bit have_prev = 1'b0;
  bit want_ratio = 1'b1;
  bit done = 1'b0;
  string tag = "R1";
  logic [31:0] lfsr = 32'h1ace_b00c;

  function automatic int aw(input int n);
    return (n == 0) ? IN_W + 4 : IN_W;
  endfunction

  function automatic longint fdiv(input longint v, input int s);
    longint d, q;
    d = 64'sd1 << s;
    q = v / d;
    if ((v % d != 0) && (v < 0)) q = q - 1;
    return q;
  endfunction

  function automatic longint top_of(input int w);
    return (64'sd1 << (w - 1)) - 1;
  endfunction

  function automatic int slice(input longint v);
    int c;
    longint t;
    t = FS / 4;
    c = 0;
    if (v > -3 * t) c++;
    if (v > -t)     c++;
    if (v >= t)     c++;
    if (v >= 3 * t) c++;
    return c;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic limit(input int n, inout longint v);
    longint hi, lo;
    hi = top_of(aw(n));
    lo = -hi - 1;
    if (v > hi) begin v = hi; if (n == 1) sat_hits++; end
    else if (v < lo) begin v = lo; if (n == 1) sat_hits++; end
  endtask

  task automatic compare();
    bit exp_t;
    exp_t = (m_cnt == (ratio ? 7 : 3));
    for (int n = 0; n < 2; n++) begin
      check(dcode[n] == 3'(m_code[n]), tag, "code vs model (R6)", dcode[n], m_code[n]);
      check(dtick[n] == exp_t, tag, "tick vs model (R4)", dtick[n], exp_t);
      check(dcode[n] <= 3'd4, "R3", "code range", dcode[n], 4);
      if (have_prev && !prev_tick)
        check(int'(dcode[n]) == prev_code[n], "R9", "code moved without tick", dcode[n], prev_code[n]);
      prev_code[n] = int'(dcode[n]);
    end
    prev_tick = tick_a;
    have_prev = 1'b1;
    if (code_a == 3'd4) seen4++;
    if (code_a == 3'd0) seen0++;
    if (code_a != 3'd2) non_mid++;
    if (tick_a) tick_count++;
  endtask

  task automatic model_next();
    int last;
    longint f, n0, n1, n2;
    if (rst) begin
      for (int n = 0; n < 2; n++) begin
        for (int k = 0; k < 3; k++) m_acc[n][k] = 0;
        m_code[n] = 2;
        m_hold[n] = 0;
      end
      m_cnt = 0;
    end else begin
      last = ratio ? 7 : 3;
      if (m_cnt == last) begin
        for (int n = 0; n < 2; n++) begin
          f  = longint'(m_code[n] - 2) * (FS / 2);
          n0 = m_acc[n][0] + fdiv(m_hold[n] - f, 2);
          n1 = m_acc[n][1] + fdiv(m_acc[n][0] - f, 2);
          n2 = m_acc[n][2] + fdiv(m_acc[n][1] - f, 1);
          limit(n, n0);
          limit(n, n1);
          limit(n, n2);
          m_acc[n][0] = n0;
          m_acc[n][1] = n1;
          m_acc[n][2] = n2;
          m_code[n]   = slice(n2);
        end
      end
      if (valid) begin
        for (int n = 0; n < 2; n++) m_hold[n] = longint'($signed(data));
      end
      m_cnt = (m_cnt >= last) ? 0 : m_cnt + 1;
    end
  endtask

  task automatic step(input bit r, input bit v, input longint d);
    @(negedge clk);
    compare();
    rst   = r;
    ratio = want_ratio;
    valid = v;
    data  = d[IN_W-1:0];
    cyc++;
    model_next();
  endtask

  // mode: 0 zero, 1 triangle, 2 +max, 3 -max, 4 swinging extremes, 5 thresholds, 6 random
  task automatic run(input string t, input int count, input int mode);
    longint thr [8] = '{32768, 32767, -32768, -32769, 98304, 98303, -98304, -98305};
    bit v;
    longint d;
    int per;
    tag = t;
    for (int i = 0; i < count; i++) begin
      per = want_ratio ? 48 : 32;
      v = (cyc % per) == 0;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      case (mode)
        0: d = 0;
        1: d = ((longint'(cyc) * 997) % 262144) - FS;
        2: d = FS - 1;
        3: d = -FS;
        4: d = ((cyc / (2 * per)) % 2 == 0) ? FS - 1 : -FS;
        5: d = thr[(cyc / per) % 8];
        default: begin
          v = lfsr[3] & lfsr[7];
          d = longint'($signed(lfsr[IN_W-1:0]));
        end
      endcase
      step(1'b0, v, d);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int n = 0; n < 2; n++) begin
      for (int k = 0; k < 3; k++) m_acc[n][k] = 0;
      m_code[n] = 2;
      m_hold[n] = 0;
    end
    tag = "R1";
    repeat (3) step(1'b1, 1'b1, 64'sd5000);
    @(negedge clk);
    check(code_a == 3'd2, "R1", "code in reset", code_a, 2);
    check(tick_a == 1'b0, "R1", "tick in reset", tick_a, 0);
    check(code_b == 3'd2, "R1", "narrow code in reset", code_b, 2);

    non_mid = 0;
    run("R5", 600, 0);
    check(non_mid == 0, "R5", "non-mid codes on zero input", non_mid, 0);

    run("R6", 3000, 1);

    want_ratio = 1'b0;
    run("R4", 8, 1);
    tick_count = 0;
    run("R4", 400, 1);
    check(tick_count == 100, "R4", "ticks in 400 clocks at 256x", tick_count, 100);
    want_ratio = 1'b1;
    run("R4", 8, 1);
    tick_count = 0;
    run("R4", 400, 1);
    check(tick_count == 50, "R4", "ticks in 400 clocks at 384x", tick_count, 50);

    seen4 = 0;
    run("R3", 1500, 2);
    check(seen4 > 0, "R3", "top code reached on +full scale", seen4, 1);
    seen0 = 0;
    run("R3", 1500, 3);
    check(seen0 > 0, "R3", "bottom code reached on -full scale", seen0, 1);

    sat_hits = 0;
    want_ratio = 1'b0;
    run("R8", 3000, 4);
    check(sat_hits > 0, "R8", "clamp events in narrow instance", sat_hits, 1);
    want_ratio = 1'b1;

    run("R7", 3000, 5);
    run("R2", 3000, 6);

    @(negedge clk);
    compare();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule